// File: doc/BRIEF.md
# Cell Interface Passive Protocol Monitor

This block watches the signals of a point-to-point cell interface and never drives them. A sender raises `clav` when it has a cell, the receiver grants with the active-low `enb_n`, and the cell then moves one byte per accepted cycle. The first byte is marked by `soc`. The monitor rebuilds each 53-byte cell from the bytes that really move. It presents the finished cell for one cycle with `cell_valid`. It also raises a separate sticky flag for each kind of protocol misuse it sees.

A byte moves in a cycle only when `clav` is high in that cycle and `enb_n` was low in the cycle before. Either side may pause between bytes in any mix: the sender by dropping `clav`, the receiver by holding `enb_n` high. A pause is never an error.

The control is a three-state machine:
- `MS_IDLE`: waiting for a start byte.
- `MS_FILL`: collecting bytes 1 to 52.
- `MS_EMIT`: the one-cycle presentation state.

Its transitions are:
- T_START: `MS_IDLE` or `MS_EMIT` to `MS_FILL`, on a moved byte with `soc` high.
- T_RESTART: `MS_FILL` to `MS_FILL`, with the counter reset, on a moved byte with `soc` high.
- T_STEP: `MS_FILL` to `MS_FILL`, on a moved byte with `soc` low that is not the last one.
- T_LAST: `MS_FILL` to `MS_EMIT`, on moved byte 52.
- T_DRAIN: `MS_EMIT` to `MS_IDLE`, when no start byte arrives.

Top module: `cell_if_monitor`

## Requirements
- R1: A byte counts as transferred only in a cycle where `clav` is 1 and `enb_n` was 0 in the previous cycle. A cycle with `enb_n` low but the previous `enb_n` high moves nothing, and neither does a cycle with `clav` low.
- R2: A transferred byte with `soc` = 1 starts a cell. Its `data` becomes byte 0, placed at `cell_data[7:0]`.
- R3: A cell holds exactly 53 bytes. Byte k appears at `cell_data[8k+7:8k]`. The cell completes on the 52nd transferred byte after byte 0.
- R4: `cell_valid` is high for exactly one cycle, the cycle after the clock edge that captured byte 52. `cell_data` holds the full cell during that cycle. A new cell may begin in that same cycle.
- R5: Pauses from `clav` low or `enb_n` high, in any interleaving between bytes, raise no flag and do not change the cell being built.
- R6: A transferred byte with `soc` = 1 while a cell is part built sets `err_soc_mid`. Assembly then restarts with that byte as byte 0.
- R7: `soc` = 1 in any cycle with `clav` = 0 sets `err_soc_noclav` at the next edge. It has no effect on assembly.
- R8: A transferred byte with `soc` = 0 while no cell is in progress sets `err_soc_missing`. The byte is discarded.
- R9: Reset clears the byte counter, the stored partial cell (`cell_data` reads all zero), every error flag and `cell_valid`.
- R10: Each error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clav | input | 1 | Sender has a cell / byte available |
| enb_n | input | 1 | Receiver grant, active low |
| soc | input | 1 | Start-of-cell marker |
| data | input | DATA_W | Byte lane |
| cell_valid | output | 1 | One-cycle completed-cell pulse |
| cell_data | output | CELL_BYTES*DATA_W | Rebuilt cell, byte 0 in the low bits |
| err_soc_mid | output | 1 | Sticky: start marker inside a cell |
| err_soc_noclav | output | 1 | Sticky: start marker while `clav` low |
| err_soc_missing | output | 1 | Sticky: byte moved with no cell open |

## Verification
A byte's fate depends on the `enb_n` of the cycle before, so the bench keeps its own copy of the previous grant. It works out whether each driven cycle moves a byte before the edge. `cell_valid` and `cell_data` are due one edge after byte 52 is captured. A sampler at every falling edge compares them with a flag and a cell snapshot that the bench arms at that capture edge. So a pulse that is early, late, missing or doubled is caught. The flags update at the edge that sees the offending cycle. The bench reads them only after idle cycles (`clav` low, `soc` low), which can move no byte and set no flag, so holding the inputs while sampling cannot change the result.

// File: rtl/cim_pkg.sv
package cim_pkg;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_FILL = 2'd1,
        MS_EMIT = 2'd2
    } mon_state_t;

endpackage

// File: rtl/cim_xfer_detect.sv
module cim_xfer_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic clav,
    input  logic enb_n,
    output logic xfer
);

    // Grant seen in the previous cycle; a byte moves when the sender is
    // still ready in the cycle after a grant.
    logic grant_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
        end else begin
            grant_q <= ~enb_n;
        end
    end

    assign xfer = clav & grant_q;

endmodule

// File: rtl/cim_fsm.sv
module cim_fsm
    import cim_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer,
    input  logic             soc,
    input  logic             clav,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_idx,
    output logic             cell_valid,
    output logic             err_soc_mid,
    output logic             err_soc_noclav,
    output logic             err_soc_missing
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_BYTES - 1);

    mon_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             start_byte, body_byte;
    logic             set_mid, set_noclav, set_missing;

    assign start_byte = xfer & soc;
    assign body_byte  = xfer & ~soc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Byte counter and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q           <= '0;
            err_soc_mid     <= 1'b0;
            err_soc_noclav  <= 1'b0;
            err_soc_missing <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (set_mid)     err_soc_mid     <= 1'b1;
            if (set_noclav)  err_soc_noclav  <= 1'b1;
            if (set_missing) err_soc_missing <= 1'b1;
        end
    end

    // Next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            MS_IDLE, MS_EMIT: begin
                if (start_byte) begin
                    state_d = MS_FILL;                   // T_START
                    cnt_d   = CNT_W'(1);
                end else begin
                    state_d = MS_IDLE;                   // T_DRAIN
                    cnt_d   = '0;
                end
            end
            MS_FILL: begin
                if (start_byte) begin
                    state_d = MS_FILL;                   // T_RESTART
                    cnt_d   = CNT_W'(1);
                end else if (body_byte) begin
                    if (cnt_q == LAST_IDX) begin
                        state_d = MS_EMIT;               // T_LAST
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_q + 1'b1;          // T_STEP
                    end
                end
            end
            default: begin
                state_d = MS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cell_valid  = (state_q == MS_EMIT);
        wr_en       = start_byte | (body_byte & (state_q == MS_FILL));
        wr_idx      = start_byte ? '0 : cnt_q;
        set_mid     = start_byte & (state_q == MS_FILL);
        set_noclav  = soc & ~clav;
        set_missing = body_byte & (state_q != MS_FILL);
    end

endmodule

// File: rtl/cim_cell_store.sv
module cim_cell_store #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = $clog2(CELL_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CNT_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [CELL_BYTES*DATA_W-1:0] cell_data
);

    for (genvar g = 0; g < CELL_BYTES; g++) begin : g_byte
        logic [DATA_W-1:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && (wr_idx == CNT_W'(g))) begin
                byte_q <= wr_data;
            end
        end

        assign cell_data[g*DATA_W +: DATA_W] = byte_q;
    end

endmodule

// File: rtl/cell_if_monitor.sv
module cell_if_monitor #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clav,
    input  logic                         enb_n,
    input  logic                         soc,
    input  logic [DATA_W-1:0]            data,
    output logic                         cell_valid,
    output logic [CELL_BYTES*DATA_W-1:0] cell_data,
    output logic                         err_soc_mid,
    output logic                         err_soc_noclav,
    output logic                         err_soc_missing
);

    localparam int CNT_W = $clog2(CELL_BYTES);

    logic             xfer;
    logic             wr_en;
    logic [CNT_W-1:0] wr_idx;

    cim_xfer_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .clav  (clav),
        .enb_n (enb_n),
        .xfer  (xfer)
    );

    cim_fsm #(
        .CELL_BYTES (CELL_BYTES),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .xfer            (xfer),
        .soc             (soc),
        .clav            (clav),
        .wr_en           (wr_en),
        .wr_idx          (wr_idx),
        .cell_valid      (cell_valid),
        .err_soc_mid     (err_soc_mid),
        .err_soc_noclav  (err_soc_noclav),
        .err_soc_missing (err_soc_missing)
    );

    cim_cell_store #(
        .DATA_W     (DATA_W),
        .CELL_BYTES (CELL_BYTES),
        .CNT_W      (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (data),
        .cell_data (cell_data)
    );

endmodule

// File: rtl/cell_if_monitor_chk.sv
module cell_if_monitor_chk #(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         clav,
    input logic                         enb_n,
    input logic                         soc,
    input logic [DATA_W-1:0]            data,
    input logic                         cell_valid,
    input logic [CELL_BYTES*DATA_W-1:0] cell_data,
    input logic                         err_soc_mid,
    input logic                         err_soc_noclav,
    input logic                         err_soc_missing
);

    localparam int CW = CELL_BYTES * DATA_W;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |=> !cell_valid);                                             // R4

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> ($past(clav) && !$past(soc) && !$past(enb_n, 2)));        // R1

    AST_LAST_BYTE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> (cell_data[CW-1 -: DATA_W] == $past(data)));              // R3

    AST_NOCLAV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (soc && !clav) |=> err_soc_noclav);                                      // R7

    AST_MID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_soc_mid |=> err_soc_mid);                                            // R10

    AST_NOCLAV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_soc_noclav |=> err_soc_noclav);                                      // R10

    AST_MISSING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_soc_missing |=> err_soc_missing);                                    // R10

endmodule

bind cell_if_monitor cell_if_monitor_chk #(
    .DATA_W     (DATA_W),
    .CELL_BYTES (CELL_BYTES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .clav            (clav),
    .enb_n           (enb_n),
    .soc             (soc),
    .data            (data),
    .cell_valid      (cell_valid),
    .cell_data       (cell_data),
    .err_soc_mid     (err_soc_mid),
    .err_soc_noclav  (err_soc_noclav),
    .err_soc_missing (err_soc_missing)
);

// File: tb/sim_cell_if_monitor.sv
`timescale 1ns/1ps
module sim_cell_if_monitor;

    localparam int DW = 8;
    localparam int NB = 53;
    localparam int CW = DW * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clav = 1'b0;
    logic          enb_n = 1'b1;
    logic          soc = 1'b0;
    logic [DW-1:0] data = '0;
    logic          cell_valid;
    logic [CW-1:0] cell_data;
    logic          err_soc_mid, err_soc_noclav, err_soc_missing;

    int checks = 0;
    int fails = 0;
    int pulses_exp = 0;
    int pulses_seen = 0;

    logic          tb_prev_act = 1'b0;
    logic          pulse_due = 1'b0;
    logic [CW-1:0] snap_cell = '0;
    logic [DW-1:0] exp_cell [NB];

    always #4 clk = ~clk;

    cell_if_monitor #(.DATA_W(DW), .CELL_BYTES(NB)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .clav            (clav),
        .enb_n           (enb_n),
        .soc             (soc),
        .data            (data),
        .cell_valid      (cell_valid),
        .cell_data       (cell_data),
        .err_soc_mid     (err_soc_mid),
        .err_soc_noclav  (err_soc_noclav),
        .err_soc_missing (err_soc_missing)
    );

    function automatic logic [CW-1:0] pack_cell();
        logic [CW-1:0] v = '0;
        for (int k = 0; k < NB; k++) v[k*DW +: DW] = exp_cell[k];
        return v;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // R4 timing and R3 content: sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && (pulse_due || cell_valid)) begin
            checks++;
            if (cell_valid !== pulse_due) begin
                fails++;
                $display("FAIL R4: cell_valid actual %0b expected %0b", cell_valid, pulse_due);
            end else if (cell_data !== snap_cell) begin
                fails++;
                $display("FAIL R3: cell_data actual %h expected %h", cell_data, snap_cell);
            end
            if (cell_valid) pulses_seen++;
        end
        pulse_due = 1'b0;
    end

    task automatic drive(input logic c, input logic e, input logic s, input logic [DW-1:0] d);
        @(negedge clk);
        clav = c; enb_n = e; soc = s; data = d;
        @(posedge clk);
        tb_prev_act = ~e;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 1'b1, 1'b0, DW'($urandom));
    endtask

    task automatic load_cell();
        for (int k = 0; k < NB; k++) exp_cell[k] = DW'($urandom);
    endtask

    // Move bytes lo..hi of exp_cell, with random pauses from either side (R5)
    task automatic xfer_bytes(input int lo, input int hi, input int pause_pct);
        int idx = lo;
        while (idx <= hi) begin
            logic c, e, go;
            if (pause_pct == 0) begin
                c = 1'b1; e = 1'b0;
            end else begin
                c = (($urandom % 100) >= pause_pct);
                e = (($urandom % 100) < pause_pct);
            end
            go = c & tb_prev_act;
            if (go) drive(c, e, (idx == 0), exp_cell[idx]);
            else    drive(c, e, 1'b0, DW'($urandom));
            if (go) begin
                if (idx == NB - 1) begin
                    pulse_due = 1'b1;
                    snap_cell = pack_cell();
                    pulses_exp++;
                end
                idx++;
            end
        end
    endtask

    task automatic check_flags(input string req, input logic m, input logic n, input logic s);
        @(negedge clk);
        check_bit({req, " err_soc_mid"}, err_soc_mid, m);
        check_bit({req, " err_soc_noclav"}, err_soc_noclav, n);
        check_bit({req, " err_soc_missing"}, err_soc_missing, s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; clav = 1'b0; enb_n = 1'b1; soc = 1'b0;
        tb_prev_act = 1'b0;
        pulse_due = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R9: reset state
        @(negedge clk);
        check_bit("R9 cell_valid", cell_valid, 1'b0);
        check_bit("R9 cell_data zero", (cell_data == '0), 1'b1);
        check_flags("R9", 1'b0, 1'b0, 1'b0);

        // R1: grant without a prior grant, then clav low: nothing moves
        drive(1'b1, 1'b0, 1'b0, 8'h11);
        drive(1'b0, 1'b1, 1'b0, 8'h22);
        check_flags("R1", 1'b0, 1'b0, 1'b0);

        // R8: a moved byte with no start marker outside a cell
        drive(1'b1, 1'b0, 1'b0, 8'h00);
        drive(1'b1, 1'b1, 1'b0, 8'h33);
        idle(1);
        check_flags("R8", 1'b0, 1'b0, 1'b1);

        // R10: flag holds over idle cycles
        idle(6);
        check_flags("R10", 1'b0, 1'b0, 1'b1);

        // R9: reset in the middle of a cell clears the partial cell and flags
        load_cell();
        xfer_bytes(0, 15, 0);
        do_reset();
        @(negedge clk);
        check_bit("R9 partial cleared", (cell_data == '0), 1'b1);
        check_flags("R9", 1'b0, 1'b0, 1'b0);

        // R2/R3/R4: a cell with no pauses
        load_cell();
        xfer_bytes(0, NB - 1, 0);
        idle(1);
        check_flags("R2", 1'b0, 1'b0, 1'b0);

        // R5: random pauses from both sides
        for (int n = 0; n < 8; n++) begin
            load_cell();
            xfer_bytes(0, NB - 1, 10 + 6 * n);
            idle($urandom % 3);
        end
        idle(1);
        check_flags("R5", 1'b0, 1'b0, 1'b0);

        // R4: back-to-back cells, next start byte in the pulse cycle
        for (int n = 0; n < 3; n++) begin
            load_cell();
            xfer_bytes(0, NB - 1, 0);
        end
        idle(2);
        check_flags("R4", 1'b0, 1'b0, 1'b0);

        // R6: start marker inside a cell restarts assembly
        load_cell();
        xfer_bytes(0, 9, 30);
        load_cell();
        xfer_bytes(0, NB - 1, 30);
        idle(1);
        check_flags("R6", 1'b1, 1'b0, 1'b0);

        // R7: start marker with clav low, assembly unaffected
        do_reset();
        load_cell();
        xfer_bytes(0, 20, 20);
        drive(1'b0, 1'b1, 1'b1, 8'h5A);
        xfer_bytes(21, NB - 1, 20);
        idle(1);
        check_flags("R7", 1'b0, 1'b1, 1'b0);

        // R4: total completed-cell pulses
        idle(2);
        checks++;
        if (pulses_seen != pulses_exp) begin
            fails++;
            $display("FAIL R4 pulse count: actual %0d expected %0d", pulses_seen, pulses_exp);
        end
        finish_run();
    end

endmodule